// File: doc/BRIEF.md
# FFT Sample Stream Reorder and Inverse-Swap Unit

This block sits between a sequential complex-sample stream and the working memory of an in-place radix-2 FFT engine. It runs one of two phases at a time. In the load phase it takes N complex samples from the upstream port and writes them to memory in natural order, so sample k goes to address k. In the drain phase it reads the finished results and streams them out. Each read uses the bit-reversed form of the sequential output position, so the scrambled result array leaves the block in natural order.

A mode bit is captured when each phase starts. When it is set, the real and imaginary parts of every sample are exchanged on the way in, or on the way out. An FFT engine that can only compute forward transforms can then produce inverse transforms as well. The memory runs at twice the stream rate. A stream sample therefore moves at most every second clock, and every memory access is a single-cycle strobe. The memory read has a latency of one cycle. A one-cycle completion pulse marks the end of each phase. The load, transform and drain phases never overlap.

Top module: `fft_io_reorder`

## Requirements
- R1: While reset is held, and right after it is released, in_ready_o, out_valid_o, done_o, mem_we_o and mem_re_o are all 0.
- R2: A pulse on in_start_i in idle starts a load phase. A pulse on out_start_i in idle starts a drain phase. If both arrive together, in_start_i wins. The inv_i value sampled with the start pulse applies to the whole phase, and later changes of inv_i have no effect on it.
- R3: In a load phase, the k-th accepted sample (in_valid_i and in_ready_o both high, k counted from 0) is written to address k. The write strobe mem_we_o is high in that same cycle.
- R4: When inverse mode is captured for a load phase, the data written is mem_wre_o = in_im_i and mem_wim_o = in_re_i. Otherwise the data passes unchanged.
- R5: in_ready_o is never high in two consecutive cycles. In a load phase it is high on every second cycle, starting with the second cycle of the phase.
- R6: In a drain phase, the k-th output sample is the memory word at address bitrev(k). Here bitrev mirrors the log2(N) address bits, so address bit i comes from bit log2(N)-1-i of k. The word is read with mem_re_o and returned on mem_rre_i and mem_rim_i one cycle later.
- R7: When inverse mode is captured for a drain phase, out_re_o carries the stored imaginary part and out_im_o carries the stored real part.
- R8: Once out_valid_o is high, it stays high with unchanged data until out_ready_i is high. Output handshakes never occur in two consecutive cycles.
- R9: done_o is high for exactly one cycle, in the cycle after the N-th transfer of a phase. The block is idle from that cycle on.
- R10: Start pulses that arrive during a phase are ignored. A load phase issues no memory reads, and a drain phase issues no writes and never raises in_ready_o.
- R11: mem_we_o and mem_re_o are never high together. A read result never overwrites an output sample that has not yet been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inv_i | input | 1 | Inverse mode, sampled at phase start |
| in_start_i | input | 1 | Start a load phase |
| out_start_i | input | 1 | Start a drain phase |
| in_valid_i | input | 1 | Upstream sample valid |
| in_re_i | input | DATA_W | Upstream real part |
| in_im_i | input | DATA_W | Upstream imaginary part |
| in_ready_o | output | 1 | Block accepts a sample this cycle |
| out_ready_i | input | 1 | Downstream accepts a sample |
| out_valid_o | output | 1 | Output sample valid |
| out_re_o | output | DATA_W | Output real part |
| out_im_o | output | DATA_W | Output imaginary part |
| done_o | output | 1 | One-cycle end-of-phase pulse |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | log2(N) | Memory address |
| mem_wre_o | output | DATA_W | Write data, real part |
| mem_wim_o | output | DATA_W | Write data, imaginary part |
| mem_rre_i | input | DATA_W | Read data, real part (one cycle after strobe) |
| mem_rim_i | input | DATA_W | Read data, imaginary part |

## Verification
The bench runs full load and drain phases with bubbles on the input side and random backpressure on the output side, and compares every sample against a bit-reversal and swap model. A design that mirrored the address wrongly, or skipped bit reversal, would deliver samples in the wrong order. A design that latched the mode bit late would swap only part of a phase, because the bench flips inv_i just after each start. Stray start pulses in the middle of a phase would restart the counters in a faulty design, which would show up as lost or duplicated samples and a misplaced done pulse. Backpressure exposes designs that drop or overwrite a held output, or that issue a second read before the first has been consumed.

// File: rtl/fft_io_pkg.sv
package fft_io_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_IN, PH_OUT} phase_e;
endpackage

// File: rtl/fft_io_swap.sv
module fft_io_swap #(
  parameter int unsigned W = 16
) (
  input  logic         swap_i,
  input  logic [W-1:0] re_i,
  input  logic [W-1:0] im_i,
  output logic [W-1:0] re_o,
  output logic [W-1:0] im_o
);
  assign re_o = swap_i ? im_i : re_i;
  assign im_o = swap_i ? re_i : im_i;
endmodule

// File: rtl/fft_io_bitrev.sv
module fft_io_bitrev #(
  parameter int unsigned AW = 10
) (
  input  logic [AW-1:0] idx_i,
  output logic [AW-1:0] rev_o
);
  for (genvar g = 0; g < AW; g++) begin : g_mirror
    assign rev_o[g] = idx_i[AW-1-g];
  end
endmodule

// File: rtl/fft_io_ctrl.sv
module fft_io_ctrl
  import fft_io_pkg::*;
#(
  parameter int unsigned N  = 1024,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_start_i,
  input  logic          out_start_i,
  input  logic          inv_i,
  input  logic          in_valid_i,
  input  logic          out_ready_i,
  output logic          in_ready_o,
  output logic          in_acc_o,
  output logic          rd_issue_o,
  output logic          rd_cap_o,
  output logic          out_valid_o,
  output logic          inv_o,
  output logic [AW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  phase_e        phase_q;
  logic          slot_q, inv_q, done_q, rd_pend_q, ov_q;
  logic [AW:0]   iss_q;
  logic [AW-1:0] dlv_q;
  logic          out_hs, last_in, last_out;

  always_comb begin
    in_ready_o = (phase_q == PH_IN) && slot_q;
    in_acc_o   = in_ready_o && in_valid_i;
    out_hs     = ov_q && out_ready_i;
    // iss_q[AW] marks that all N reads are issued
    rd_issue_o = (phase_q == PH_OUT) && !iss_q[AW] && !rd_pend_q && (!ov_q || out_ready_i);
    last_in    = in_acc_o && (iss_q[AW-1:0] == LAST);
    last_out   = out_hs && (dlv_q == LAST);
  end

  assign rd_cap_o    = rd_pend_q;
  assign out_valid_o = ov_q;
  assign inv_o       = inv_q;
  assign idx_o       = iss_q[AW-1:0];
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      slot_q    <= 1'b0;
      inv_q     <= 1'b0;
      done_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      ov_q      <= 1'b0;
      iss_q     <= '0;
      dlv_q     <= '0;
    end else begin
      done_q    <= last_in || last_out;
      rd_pend_q <= rd_issue_o;
      if (rd_pend_q)   ov_q <= 1'b1;
      else if (out_hs) ov_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (in_start_i) begin
            phase_q <= PH_IN;
            inv_q   <= inv_i;
            iss_q   <= '0;
            slot_q  <= 1'b0;
          end else if (out_start_i) begin
            phase_q <= PH_OUT;
            inv_q   <= inv_i;
            iss_q   <= '0;
            dlv_q   <= '0;
          end
        end
        PH_IN: begin
          slot_q <= ~slot_q;
          if (in_acc_o) iss_q <= iss_q + 1'b1;
          if (last_in)  phase_q <= PH_IDLE;
        end
        PH_OUT: begin
          if (rd_issue_o) iss_q <= iss_q + 1'b1;
          if (out_hs)     dlv_q <= dlv_q + 1'b1;
          if (last_out)   phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R5
  in_rdy_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |=> !in_ready_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == PH_IDLE));

  // R10
  in_phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IN && !in_acc_o) |=> (phase_q == PH_IN));

  // R11
  rd_cap_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> !ov_q);
endmodule

// File: rtl/fft_io_reorder.sv
module fft_io_reorder #(
  parameter int unsigned N      = 1024,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned AW    = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inv_i,
  input  logic              in_start_i,
  input  logic              out_start_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_re_i,
  input  logic [DATA_W-1:0] in_im_i,
  output logic              in_ready_o,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_re_o,
  output logic [DATA_W-1:0] out_im_o,
  output logic              done_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DATA_W-1:0] mem_wre_o,
  output logic [DATA_W-1:0] mem_wim_o,
  input  logic [DATA_W-1:0] mem_rre_i,
  input  logic [DATA_W-1:0] mem_rim_i
);
  logic              in_acc, rd_issue, rd_cap, inv_q;
  logic [AW-1:0]     idx, idx_rev;
  logic [DATA_W-1:0] rd_re_sw, rd_im_sw;
  logic [DATA_W-1:0] out_re_q, out_im_q;

  fft_io_ctrl #(.N(N)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_start_i  (in_start_i),
    .out_start_i (out_start_i),
    .inv_i       (inv_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .in_acc_o    (in_acc),
    .rd_issue_o  (rd_issue),
    .rd_cap_o    (rd_cap),
    .out_valid_o (out_valid_o),
    .inv_o       (inv_q),
    .idx_o       (idx),
    .done_o      (done_o)
  );

  fft_io_bitrev #(.AW(AW)) u_rev (
    .idx_i (idx),
    .rev_o (idx_rev)
  );

  fft_io_swap #(.W(DATA_W)) u_swap_in (
    .swap_i (inv_q),
    .re_i   (in_re_i),
    .im_i   (in_im_i),
    .re_o   (mem_wre_o),
    .im_o   (mem_wim_o)
  );

  fft_io_swap #(.W(DATA_W)) u_swap_out (
    .swap_i (inv_q),
    .re_i   (mem_rre_i),
    .im_i   (mem_rim_i),
    .re_o   (rd_re_sw),
    .im_o   (rd_im_sw)
  );

  assign mem_we_o   = in_acc;
  assign mem_re_o   = rd_issue;
  assign mem_addr_o = rd_issue ? idx_rev : idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_re_q <= '0;
      out_im_q <= '0;
    end else if (rd_cap) begin
      out_re_q <= rd_re_sw;
      out_im_q <= rd_im_sw;
    end
  end

  assign out_re_o = out_re_q;
  assign out_im_o = out_im_q;

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_re_o) && $stable(out_im_o)));

  // R11
  mem_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  // R3
  wr_in_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (in_ready_o && in_valid_i));
endmodule

// File: tb/fft_io_reorder_tb.sv
module fft_io_reorder_tb_top;
  localparam int N  = 1024;
  localparam int DW = 16;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv = 1'b0, in_start = 1'b0, out_start = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic in_ready, out_valid, done, mem_we, mem_re;
  logic [DW-1:0] out_re, out_im, mem_wre, mem_wim;
  logic [DW-1:0] mem_rre = '0, mem_rim = '0;
  logic [AW-1:0] mem_addr;
  logic [2*DW-1:0] bmem [N];
  logic [15:0] lf = 16'hACE1;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fft_io_reorder #(.N(N), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .inv_i(inv),
    .in_start_i(in_start), .out_start_i(out_start),
    .in_valid_i(in_valid), .in_re_i(in_re), .in_im_i(in_im), .in_ready_o(in_ready),
    .out_ready_i(out_ready), .out_valid_o(out_valid), .out_re_o(out_re), .out_im_o(out_im),
    .done_o(done), .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wre_o(mem_wre), .mem_wim_o(mem_wim), .mem_rre_i(mem_rre), .mem_rim_i(mem_rim)
  );

  always_ff @(posedge clk) begin
    if (mem_we) bmem[mem_addr] <= {mem_wre, mem_wim};
    if (mem_re) {mem_rre, mem_rim} <= bmem[mem_addr];
  end

  function automatic logic [2*DW-1:0] pat(int i);
    logic [DW-1:0] r, m;
    r = DW'(i * 37 + 5);
    m = DW'(16'hC3A0 ^ i);
    return {r, m};
  endfunction

  function automatic logic [2*DW-1:0] swp(logic [2*DW-1:0] w);
    return {w[DW-1:0], w[2*DW-1:DW]};
  endfunction

  function automatic int brev(int k);
    int r = 0;
    for (int b = 0; b < AW; b++) if (k[b]) r |= 1 << (AW - 1 - b);
    return r;
  endfunction

  function automatic logic [15:0] lf_nx(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic start_phase(bit load, bit mode);
    @(negedge clk);
    inv = mode;
    in_start = load;
    out_start = !load;
    @(negedge clk);
    in_start = 1'b0;
    out_start = 1'b0;
    inv = !mode; // R2: later changes must not matter
  endtask

  task automatic run_load(bit mode, bit gaps);
    int k = 0, pace_err = 0, spur = 0, mism = 0;
    bit prev_rdy = 0, acc;
    start_phase(1'b1, mode);
    while (k < N) begin
      in_start  = (k == 7);   // R10 stray starts
      out_start = (k == 7);
      in_valid  = gaps ? lf[0] : 1'b1;
      lf = lf_nx(lf);
      {in_re, in_im} = pat(k);
      #1;
      if (in_ready && prev_rdy) pace_err++;
      if (mem_re) spur++;
      acc = in_valid && in_ready;
      prev_rdy = in_ready;
      @(posedge clk);
      if (acc) k++;
      @(negedge clk);
    end
    in_valid = 1'b0; in_start = 1'b0; out_start = 1'b0;
    chk(done == 1'b1, "R9", "done after last load", 64'(done), 64'd1);
    chk(in_ready == 1'b0, "R9", "idle after load", 64'(in_ready), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
    chk(pace_err == 0, "R5", "back-to-back ready", 64'(pace_err), 64'd0);
    chk(spur == 0, "R10", "read during load", 64'(spur), 64'd0);
    for (int a = 0; a < N; a++) begin
      logic [2*DW-1:0] e;
      e = mode ? swp(pat(a)) : pat(a);
      if (bmem[a] !== e) begin
        mism++;
        if (mism < 4) chk(1'b0, mode ? "R4" : "R3", "mem word", 64'(bmem[a]), 64'(e));
      end
    end
    chk(mism == 0, mode ? "R4" : "R3", "mem mismatches", 64'(mism), 64'd0);
  endtask

  task automatic run_drain(bit in_mode, bit out_mode, bit bp);
    int k = 0, pace_err = 0, hold_err = 0, spur = 0, mism = 0;
    bit prev_v = 0, prev_r = 0, prev_hs = 0, hs;
    logic [2*DW-1:0] prev_d = '0, e;
    start_phase(1'b0, out_mode);
    while (k < N) begin
      in_start  = (k == 3);   // R10 stray start
      out_ready = bp ? lf[0] : 1'b1;
      lf = lf_nx(lf);
      #1;
      if (in_ready || mem_we) spur++;
      if (prev_v && !prev_r && (!out_valid || {out_re, out_im} !== prev_d)) hold_err++;
      hs = out_valid && out_ready;
      if (hs && prev_hs) pace_err++;
      if (hs) begin
        e = in_mode ? swp(pat(brev(k))) : pat(brev(k));
        if (out_mode) e = swp(e);
        if ({out_re, out_im} !== e) begin
          mism++;
          if (mism < 4) chk(1'b0, out_mode ? "R7" : "R6", "out word", 64'({out_re, out_im}), 64'(e));
        end
      end
      prev_v = out_valid; prev_r = out_ready; prev_hs = hs; prev_d = {out_re, out_im};
      @(posedge clk);
      if (hs) k++;
      @(negedge clk);
    end
    in_start = 1'b0; out_ready = 1'b0;
    chk(mism == 0, out_mode ? "R7" : "R6", "drain mismatches", 64'(mism), 64'd0);
    chk(done == 1'b1, "R9", "done after last drain", 64'(done), 64'd1);
    chk(out_valid == 1'b0, "R9", "no valid after drain", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
    chk(hold_err == 0, "R8", "held output changed", 64'(hold_err), 64'd0);
    chk(pace_err == 0, "R8", "back-to-back handshake", 64'(pace_err), 64'd0);
    chk(spur == 0, "R10", "write or ready during drain", 64'(spur), 64'd0);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk({in_ready, out_valid, done, mem_we, mem_re} == 5'b0, "R1", "outputs in reset",
        64'({in_ready, out_valid, done, mem_we, mem_re}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({in_ready, out_valid, done, mem_we, mem_re} == 5'b0, "R1", "outputs after reset",
        64'({in_ready, out_valid, done, mem_we, mem_re}), 64'd0);
  endtask

  task automatic test_forward();
    run_load(1'b0, 1'b0);   // R3
    run_drain(1'b0, 1'b0, 1'b0); // R6
  endtask

  task automatic test_inv_load();
    run_load(1'b1, 1'b1);   // R4 with bubbles
    run_drain(1'b1, 1'b0, 1'b1);
  endtask

  task automatic test_inv_drain();
    run_load(1'b0, 1'b1);
    run_drain(1'b0, 1'b1, 1'b1); // R7 with backpressure
  endtask

  task automatic test_round_trip();
    run_load(1'b1, 1'b0);
    run_drain(1'b1, 1'b1, 1'b1); // R2 mode latched per phase
  endtask

  initial begin
    test_reset();
    test_forward();
    test_inv_load();
    test_inv_drain();
    test_round_trip();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule